// File: doc/BRIEF.md
# Coded-Ratio Serial Clock Divider

This block turns a fast module clock into the bit clock of a serial shift interface. The divide ratio is chosen by a 5-bit rate code rather than a binary count. Ratios step alternately by 3/2 and 4/3 (3, 4, 6, 8, 12, 16, ... 768, 1024), so the available bit rates are about twice as dense as a power-of-two divider gives, and odd ratios are included.

Along with the serial clock, the block drives two single-cycle strobes. One marks the cycle in which the shifter should put out a new bit. The other marks the cycle in which it should sample the incoming bit. Clock idle level and sampling edge are programmable.

The block runs in whole words of `WORD_BITS` bits. The code, polarity and phase are captured when a word starts and are held until that word ends, so a setting that changes in mid-flight never produces a short or stretched bit.

Top module: `spi_clk_div`

## Requirements
- R1: Rate code c (2 to 18) gives a serial clock period of D(c) module cycles, where D(2)=4, and for c>2, D(c) = D(c-1)*3/2 when c is odd and D(c-1)*4/3 when c is even (4, 6, 8, 12, ... 1024). A word is WORD_BITS (default 8) periods.
- R2: Rate code 0 produces no clock edges and no strobes. The serial clock stays at its idle level.
- R3: Rate code 1 gives a period of 3 cycles when `fast_ok` is 1. When `fast_ok` is 0, code 1 behaves like code 0.
- R4: A code above the parameter MAX_CODE (default 18) is treated as MAX_CODE. With the default, every code from 18 to 31 gives period 1024.
- R5: In each period the clock is at the active level (the opposite of idle) for floor(D/2) cycles, and at the idle level for ceil(D/2) cycles.
- R6: While idle, `sclk` equals `cpol`. After a word ends it returns to `cpol`.
- R7: The leading edge is the change from idle to active level, and the trailing edge is the change back. With `cpha`=0, `capture_stb` pulses on leading edges and `launch_stb` pulses on trailing edges. With `cpha`=1 the roles swap. Each pulse is one cycle wide, falls in the cycle in which `sclk` first shows the new level, and no strobe pulses outside edge cycles.
- R8: From idle, if `en` is 1 and the code is valid at a clock edge, the first leading edge appears in `sclk` right after that edge.
- R9: A code change during a word has no effect until that word has finished. The next word, if `en` is still 1, starts with the new code.
- R10: Dropping `en` during a word does not cut the word short. All WORD_BITS bits complete, and then the clock stops.
- R11: During reset `sclk`, `launch_stb` and `capture_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request, sampled at word boundaries |
| rate_code | input | 5 | Coded divide ratio |
| fast_ok | input | 1 | Permits code 1 (divide by 3) |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sclk | output | 1 | Serial bit clock |
| launch_stb | output | 1 | One-cycle pulse: drive next bit |
| capture_stb | output | 1 | One-cycle pulse: sample bit |

## Verification
The bench aims at the divide-by-3 case. A divider that rounds the odd half the wrong way would show a two-cycle active phase, and one that ignores `fast_ok` would clock when it must stay silent. It changes the code in the middle of a word and drops `en` in the middle of a word. A design that reloads its divisor at once would space the early edges wrongly, and one that stops at once would deliver fewer than sixteen leading edges. It also runs codes beyond the cap, where a missing clamp would give a wrong or zero period, and it swaps polarity and phase so that a swapped strobe mapping or a wrong idle level shows up.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  typedef enum logic {
    HALF_IDLE = 1'b0,
    HALF_ACT  = 1'b1
  } half_e;
endpackage

// File: rtl/spi_rate_decode.sv
module spi_rate_decode #(
  parameter int CODE_W   = 5,
  parameter int DIV_W    = 11,
  parameter int MAX_CODE = 18
) (
  input  logic [CODE_W-1:0] code,
  input  logic              fast_ok,
  output logic              valid,
  output logic [DIV_W-1:0]  div
);
  localparam logic [CODE_W-1:0] CAP = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0] clamped;
  logic [CODE_W-1:0] step;
  logic [CODE_W-1:0] octave;

  always_comb begin
    clamped = (code > CAP) ? CAP : code;
    step    = clamped - CODE_W'(2);
    octave  = step >> 1;
    valid   = 1'b0;
    div     = '0;
    if (clamped == CODE_W'(1)) begin
      valid = fast_ok;
      div   = DIV_W'(3);
    end else if (clamped >= CODE_W'(2)) begin
      valid = 1'b1;
      // R1: even steps are powers of two from 4, odd steps sit at 3/2 of them
      if (step[0]) div = DIV_W'(3) << (octave + CODE_W'(1));
      else         div = DIV_W'(4) << octave;
    end
  end
endmodule

// File: rtl/spi_edge_timer.sv
module spi_edge_timer
  import spi_div_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int WORD_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             valid,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             launch_stb,
  output logic             capture_stb
);
  localparam int CNT_W = DIV_W - 1;
  localparam int BIT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  logic             run_q, run_d;
  half_e            half_q, half_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [DIV_W-1:0] ndiv_q, ndiv_d;
  logic             pol_q, pol_d;
  logic             pha_q, pha_d;
  logic             sclk_q, sclk_d;
  logic             lead_q, lead_d;
  logic             trail_q, trail_d;

  logic             load_ok;
  logic [DIV_W-1:0] act_len, idl_len, new_act;

  assign load_ok = en && valid;
  assign act_len = ndiv_q >> 1;
  assign idl_len = ndiv_q - act_len;
  assign new_act = div >> 1;

  always_comb begin
    run_d   = run_q;
    half_d  = half_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    ndiv_d  = ndiv_q;
    pol_d   = pol_q;
    pha_d   = pha_q;
    sclk_d  = sclk_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (!run_q) begin
      pol_d  = cpol;
      pha_d  = cpha;
      sclk_d = cpol;
      bit_d  = '0;
      if (load_ok) begin
        run_d  = 1'b1;
        ndiv_d = div;
        half_d = HALF_ACT;
        sclk_d = ~cpol;
        lead_d = 1'b1;
        cnt_d  = CNT_W'(new_act - DIV_W'(1));
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (half_q == HALF_ACT) begin
      half_d  = HALF_IDLE;
      sclk_d  = pol_q;
      trail_d = 1'b1;
      cnt_d   = CNT_W'(idl_len - DIV_W'(1));
    end else if (bit_q != LAST_BIT) begin
      bit_d  = bit_q + BIT_W'(1);
      half_d = HALF_ACT;
      sclk_d = ~pol_q;
      lead_d = 1'b1;
      cnt_d  = CNT_W'(act_len - DIV_W'(1));
    end else begin
      bit_d = '0;
      if (load_ok && (cpol == pol_q)) begin
        ndiv_d = div;
        pha_d  = cpha;
        half_d = HALF_ACT;
        sclk_d = ~pol_q;
        lead_d = 1'b1;
        cnt_d  = CNT_W'(new_act - DIV_W'(1));
      end else begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      half_q  <= HALF_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      ndiv_q  <= '0;
      pol_q   <= 1'b0;
      pha_q   <= 1'b0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      half_q  <= half_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      ndiv_q  <= ndiv_d;
      pol_q   <= pol_d;
      pha_q   <= pha_d;
      sclk_q  <= sclk_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign sclk        = sclk_q;
  assign launch_stb  = pha_q ? lead_q  : trail_q;
  assign capture_stb = pha_q ? trail_q : lead_q;

  // R8
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && en && valid) |=> (run_q && lead_q && ndiv_q >= DIV_W'(3)));

  // R7
  lead_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> (sclk_q != $past(sclk_q)));

  // R7
  lead_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |=> !lead_q);

  // R5
  act_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && half_q == HALF_ACT) |-> (DIV_W'(cnt_q) < (ndiv_q >> 1)));

  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && bit_q != '0) |-> $stable(ndiv_q));
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CODE_W    = 5,
  parameter int DIV_W     = 11,
  parameter int MAX_CODE  = 18,
  parameter int WORD_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              fast_ok,
  input  logic              cpol,
  input  logic              cpha,
  output logic              sclk,
  output logic              launch_stb,
  output logic              capture_stb
);
  logic             code_valid;
  logic [DIV_W-1:0] code_div;

  spi_rate_decode #(
    .CODE_W  (CODE_W),
    .DIV_W   (DIV_W),
    .MAX_CODE(MAX_CODE)
  ) u_decode (
    .code   (rate_code),
    .fast_ok(fast_ok),
    .valid  (code_valid),
    .div    (code_div)
  );

  spi_edge_timer #(
    .DIV_W    (DIV_W),
    .WORD_BITS(WORD_BITS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .valid      (code_valid),
    .div        (code_div),
    .cpol       (cpol),
    .cpha       (cpha),
    .sclk       (sclk),
    .launch_stb (launch_stb),
    .capture_stb(capture_stb)
  );
endmodule

// File: tb/spi_clk_div_tb.sv
module spi_clk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [4:0] rate_code;
  logic       fast_ok;
  logic       cpol;
  logic       cpha;
  logic       sclk;
  logic       launch_stb;
  logic       capture_stb;

  int total = 0;
  int bad = 0;
  int lead_t[64];
  int n_lead;
  int err_strobe;
  int err_act;
  int err_level;
  logic final_level;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_code(rate_code),
    .fast_ok(fast_ok), .cpol(cpol), .cpha(cpha), .sclk(sclk),
    .launch_stb(launch_stb), .capture_stb(capture_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input int code, input bit fast);
    int c = (code > 18) ? 18 : code;
    int d = 3;
    if (c == 0) return 0;
    if (c == 1) return fast ? 3 : 0;
    for (int i = 2; i <= c; i++) d = (i % 2 == 0) ? (d * 4 / 3) : (d * 3 / 2);
    return d;
  endfunction

  // Samples at negedges t=1..cycles after inputs were driven at the negedge t=0.
  task automatic watch(input int cycles, input logic pol, input logic ph,
                       input int act_exp, input int drop_at,
                       input int chg_at, input logic [4:0] chg_code);
    logic prev = pol;
    int last_lead = -1;
    n_lead = 0; err_strobe = 0; err_act = 0; err_level = 0;
    for (int t = 1; t <= cycles; t++) begin
      @(negedge clk);
      if (sclk != pol && prev == pol) begin
        if (n_lead < 64) lead_t[n_lead] = t;
        n_lead++;
        last_lead = t;
        if (capture_stb !== !ph || launch_stb !== ph) err_strobe++;
      end else if (sclk == pol && prev != pol) begin
        if (act_exp > 0 && t - last_lead != act_exp) err_act++;
        if (capture_stb !== ph || launch_stb !== !ph) err_strobe++;
      end else begin
        if (capture_stb !== 1'b0 || launch_stb !== 1'b0) err_strobe++;
      end
      if (act_exp == 0 && sclk !== pol) err_level++;
      prev = sclk;
      if (t == drop_at) en = 1'b0;
      if (t == chg_at) rate_code = chg_code;
    end
    final_level = sclk;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; rate_code = 5'd2; fast_ok = 1'b0; cpol = 1'b0; cpha = 1'b0;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R11 sclk in reset", sclk, 0);
    check(launch_stb == 1'b0 && capture_stb == 1'b0, "R11 strobes in reset",
          {launch_stb, capture_stb}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_word(input logic [4:0] code, input bit fast, input logic pol,
                        input logic ph, input string req);
    int n = exp_div(code, fast);
    int spacing_err = 0;
    cpol = pol; cpha = ph; fast_ok = fast;
    repeat (2) @(negedge clk);
    check(sclk == pol, "R6 idle level", sclk, pol);
    rate_code = code; en = 1'b1;
    watch(NBITS * n + 12, pol, ph, n / 2, 1, 0, 5'd0);
    check(n_lead == NBITS, {req, " lead count"}, n_lead, NBITS);
    check(lead_t[0] == 1, "R8 first lead timing", lead_t[0], 1);
    for (int i = 1; i < NBITS; i++)
      if (lead_t[i] - lead_t[i-1] != n) spacing_err++;
    check(spacing_err == 0, {req, " period"}, lead_t[1] - lead_t[0], n);
    check(err_act == 0, "R5 active phase length", err_act, 0);
    check(err_strobe == 0, "R7 strobe placement", err_strobe, 0);
    check(final_level == pol, "R6 idle after word", final_level, pol);
  endtask

  task automatic t_dead(input logic [4:0] code, input bit fast, input logic pol, input string req);
    cpol = pol; cpha = 1'b0; fast_ok = fast; rate_code = code;
    repeat (2) @(negedge clk);
    en = 1'b1;
    watch(30, pol, 1'b0, 0, 20, 0, 5'd0);
    check(n_lead == 0, {req, " no edges"}, n_lead, 0);
    check(err_level == 0 && err_strobe == 0, {req, " quiet outputs"}, err_level + err_strobe, 0);
  endtask

  task automatic t_midword();
    int e = 0;
    cpol = 1'b0; cpha = 1'b1; fast_ok = 1'b0;
    repeat (2) @(negedge clk);
    rate_code = 5'd2; en = 1'b1;
    watch(120, 1'b0, 1'b1, 0, 40, 10, 5'd4);
    check(n_lead == 2 * NBITS, "R10 words complete after en drop", n_lead, 2 * NBITS);
    for (int i = 0; i < 16; i++) begin
      if (i < 8 && lead_t[i] != 1 + 4 * i) e++;
      if (i >= 8 && lead_t[i] != 33 + 8 * (i - 8)) e++;
    end
    check(e == 0, "R9 code held to word end", e, 0);
    check(err_strobe == 0, "R7 strobes in two-word run", err_strobe, 0);
    check(final_level == 1'b0, "R10 stopped at idle", final_level, 0);
  endtask

  initial begin
    t_reset();
    t_word(5'd2, 1'b0, 1'b0, 1'b0, "R1 code2");
    t_word(5'd3, 1'b0, 1'b1, 1'b1, "R1 code3");
    t_word(5'd5, 1'b0, 1'b1, 1'b0, "R1 code5");
    t_word(5'd9, 1'b0, 1'b0, 1'b1, "R1 code9");
    t_word(5'd1, 1'b1, 1'b0, 1'b1, "R3 code1 fast");
    t_dead(5'd0, 1'b1, 1'b1, "R2 code0");
    t_dead(5'd1, 1'b0, 1'b0, "R3 code1 no fast");
    t_midword();
    t_word(5'd31, 1'b0, 1'b0, 1'b0, "R4 code31 clamped");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule